// File: doc/BRIEF.md
# Multi-Core Dedicated-Channel Message Broadcast Fabric

This block links a set of cores through a shared broadcast medium in which every core owns a private transmit channel. A core posts a message on its own channel together with a destination mask that selects one core, a group of cores, or every core. Each receiver watches all the channels in parallel and keeps only the messages whose mask selects it. Because no two senders ever share a channel, there is no arbiter and no routing, and any number of cores can send in the same cycle.

On the receive side, every incoming message is first caught in a per-sender holding register owned by that receiver. The holding registers drain into a per-receiver FIFO one message per cycle, lowest sender index first. Each message carries its sender index out of the FIFO so that a consumer can match on the origin. When a receiver's FIFO fills and its holding register for a given sender is still occupied, that sender sees ready fall. A multicast is taken only when every receiver it names can take it, so no message is dropped or partly delivered.

Top module: `bcast_fabric`

## Requirements
- R1: While reset is asserted and directly after it is released, every `tx_ready` bit is 1 and every `rx_valid` bit is 0.
- R2: A message taken from sender s whose mask (bits `tx_dest[s*NCORE +: NCORE]`, bit r selects receiver r) has a single bit r set appears only at receiver r, with the same data and `rx_src` equal to s.
- R3: A mask with all bits set hands an identical copy, tagged with the sender index, to every receiver, the sender included.
- R4: A message taken at clock edge k by a receiver whose FIFO and holding registers are empty shows `rx_valid` high right after edge k+1, the same for every sender/receiver pair.
- R5: Acceptance of one sender never depends on another sender's traffic: all senders can be taken in the same cycle.
- R6: Messages that reach one receiver in the same cycle leave its FIFO in ascending order of sender index.
- R7: A full receive FIFO keeps the holding register occupied, which lowers `tx_ready` for each sender with a pending message in it; no message is lost or duplicated, and messages from one sender to one receiver keep their order.
- R8: A message with an all-zero mask is taken at once (`tx_ready` high) and delivered nowhere.
- R9: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and `rx_src` stay unchanged.
- R10: A multicast is taken only in a cycle when every receiver it names has room for it; no receiver ever gets a part-delivered copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | NCORE | Per-sender message present |
| tx_ready | output | NCORE | Per-sender message taken this cycle when valid |
| tx_dest | input | NCORE*NCORE | Per-sender destination mask, sender s at bits s*NCORE +: NCORE |
| tx_data | input | NCORE*DW | Per-sender payload, sender s at bits s*DW +: DW |
| rx_valid | output | NCORE | Per-receiver FIFO head present |
| rx_ready | input | NCORE | Per-receiver pop of the FIFO head |
| rx_data | output | NCORE*DW | Per-receiver head payload |
| rx_src | output | NCORE*IW | Per-receiver head sender index, IW = clog2(NCORE) |

## Verification
The interesting overlap is several senders landing on one receiver in the same cycle while that receiver's FIFO is already full, so priority draining and backpressure act together. The bench fills a small receive FIFO by holding its consumer back, then stacks pending messages from different senders, including a multicast that names a free receiver as well, and checks that the blocked senders lose ready, that the free receiver sees only one copy, and that after release every message comes out once, in per-sender order. Priority ordering is judged separately by a same-cycle four-way hit on one receiver, and a long random run with random backpressure is scored against per-pair expected queues.

// File: rtl/bcf_pkg.sv
package bcf_pkg;

  // index width for a count of cores, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bcf_fifo.sv
module bcf_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW:0]  wp, wp_n, rp, rp_n;
  logic [W-1:0] mem [DEPTH];
  logic         do_wr, do_rd;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp[AW-1:0]];

  always_comb begin
    wp_n = wp;
    rp_n = rp;
    if (do_wr) wp_n = wp + 1'b1;
    if (do_rd) rp_n = rp + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      wp <= wp_n;
      rp <= rp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[AW-1:0]] <= wr_data;
  end

endmodule

// File: rtl/bcf_admit.sv
module bcf_admit #(
  parameter int NCORE = 4
) (
  input  logic [NCORE-1:0]       tx_valid,
  input  logic [NCORE*NCORE-1:0] tx_dest,
  input  logic [NCORE*NCORE-1:0] slot_busy,
  output logic [NCORE-1:0]       tx_ready,
  output logic [NCORE*NCORE-1:0] cap_en
);
  logic [NCORE-1:0] blocked;

  // a sender is held back if any receiver it names still holds its last message
  always_comb begin
    for (int s = 0; s < NCORE; s++) begin
      blocked[s] = 1'b0;
      for (int r = 0; r < NCORE; r++)
        blocked[s] = blocked[s] | (tx_dest[s*NCORE+r] & slot_busy[r*NCORE+s]);
    end
  end

  assign tx_ready = ~blocked;

  // capture strobe per receiver r, per sender s
  always_comb begin
    for (int r = 0; r < NCORE; r++)
      for (int s = 0; s < NCORE; s++)
        cap_en[r*NCORE+s] = tx_valid[s] & ~blocked[s] & tx_dest[s*NCORE+r];
  end

endmodule

// File: rtl/bcf_rx_stage.sv
module bcf_rx_stage #(
  parameter int NCORE = 4,
  parameter int DW    = 8,
  parameter int IW    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      cap_en,
  input  logic [NCORE*DW-1:0]   cap_data,
  output logic [NCORE-1:0]      busy,
  output logic                  push_valid,
  output logic [DW-1:0]         push_data,
  output logic [IW-1:0]         push_src,
  input  logic                  push_ready
);
  logic [NCORE-1:0] hold_v, hold_v_n, drain;
  logic [DW-1:0]    hold_d [NCORE];
  logic [IW-1:0]    pick;

  // lowest occupied sender slot wins
  always_comb begin
    pick = '0;
    for (int s = NCORE - 1; s >= 0; s--)
      if (hold_v[s]) pick = IW'(s);
  end

  assign push_valid = |hold_v;
  assign push_data  = hold_d[pick];
  assign push_src   = pick;
  assign busy       = hold_v;

  always_comb begin
    for (int s = 0; s < NCORE; s++)
      drain[s] = push_valid && push_ready && (pick == IW'(s));
  end

  always_comb begin
    hold_v_n = (hold_v & ~drain) | cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_v <= '0;
    else        hold_v <= hold_v_n;
  end

  for (genvar s = 0; s < NCORE; s++) begin : g_hold
    always_ff @(posedge clk) begin
      if (cap_en[s]) hold_d[s] <= cap_data[s*DW +: DW];
    end
  end

endmodule

// File: rtl/bcast_fabric.sv
module bcast_fabric #(
  parameter int NCORE  = 4,
  parameter int DW     = 8,
  parameter int FDEPTH = 4,
  localparam int IW    = bcf_pkg::idx_w(NCORE)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCORE-1:0]       tx_valid,
  output logic [NCORE-1:0]       tx_ready,
  input  logic [NCORE*NCORE-1:0] tx_dest,
  input  logic [NCORE*DW-1:0]    tx_data,
  output logic [NCORE-1:0]       rx_valid,
  input  logic [NCORE-1:0]       rx_ready,
  output logic [NCORE*DW-1:0]    rx_data,
  output logic [NCORE*IW-1:0]    rx_src
);
  localparam int EW = IW + DW;

  logic [NCORE*NCORE-1:0] slot_busy;
  logic [NCORE*NCORE-1:0] cap_en;

  bcf_admit #(.NCORE(NCORE)) u_admit (
    .tx_valid  (tx_valid),
    .tx_dest   (tx_dest),
    .slot_busy (slot_busy),
    .tx_ready  (tx_ready),
    .cap_en    (cap_en)
  );

  for (genvar r = 0; r < NCORE; r++) begin : g_rx
    logic          push_valid, fifo_full, fifo_empty;
    logic [DW-1:0] push_data;
    logic [IW-1:0] push_src;
    logic [EW-1:0] head;

    bcf_rx_stage #(.NCORE(NCORE), .DW(DW), .IW(IW)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_en     (cap_en[r*NCORE +: NCORE]),
      .cap_data   (tx_data),
      .busy       (slot_busy[r*NCORE +: NCORE]),
      .push_valid (push_valid),
      .push_data  (push_data),
      .push_src   (push_src),
      .push_ready (!fifo_full)
    );

    bcf_fifo #(.W(EW), .DEPTH(FDEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_valid),
      .wr_data ({push_src, push_data}),
      .full    (fifo_full),
      .rd_en   (rx_ready[r]),
      .rd_data (head),
      .empty   (fifo_empty)
    );

    assign rx_valid[r]           = !fifo_empty;
    assign rx_data[r*DW +: DW]   = head[DW-1:0];
    assign rx_src[r*IW +: IW]    = head[DW +: IW];
  end

endmodule

// File: rtl/bcf_checker.sv
module bcf_checker #(
  parameter int NCORE = 4,
  parameter int DW    = 8,
  localparam int IW   = bcf_pkg::idx_w(NCORE)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCORE-1:0]       tx_valid,
  input logic [NCORE-1:0]       tx_ready,
  input logic [NCORE*NCORE-1:0] tx_dest,
  input logic [NCORE-1:0]       rx_valid,
  input logic [NCORE-1:0]       rx_ready,
  input logic [NCORE*DW-1:0]    rx_data,
  input logic [NCORE*IW-1:0]    rx_src,
  input logic [NCORE*NCORE-1:0] slot_busy
);
  logic [NCORE*NCORE-1:0] hit;

  always_comb begin
    for (int r = 0; r < NCORE; r++)
      for (int s = 0; s < NCORE; s++)
        hit[r*NCORE+s] = tx_valid[s] & tx_ready[s] & tx_dest[s*NCORE+r];
  end

  for (genvar r = 0; r < NCORE; r++) begin : g_r
    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid[r] && !rx_ready[r]) |=>
        (rx_valid[r] && $stable(rx_data[r*DW +: DW]) && $stable(rx_src[r*IW +: IW])));

    assert_no_phantom_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_valid[r] && slot_busy[r*NCORE +: NCORE] == '0 && hit[r*NCORE +: NCORE] == '0)
        |=> !rx_valid[r]);

    assert_uniform_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(hit[r*NCORE +: NCORE]) == 1 && slot_busy[r*NCORE +: NCORE] == '0 && !rx_valid[r])
        |-> ##2 rx_valid[r]);

    for (genvar s = 0; s < NCORE; s++) begin : g_s
      assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit[r*NCORE+s] |=> slot_busy[r*NCORE+s]);
    end
  end

  for (genvar s = 0; s < NCORE; s++) begin : g_tx
    assert_zero_mask_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[s] && tx_dest[s*NCORE +: NCORE] == '0) |-> tx_ready[s]);
  end

endmodule

bind bcast_fabric bcf_checker #(.NCORE(NCORE), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_dest   (tx_dest),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .rx_src    (rx_src),
  .slot_busy (slot_busy)
);

// File: tb/sim_bcast_fabric.sv
`timescale 1ns/1ps
module sim_bcast_fabric;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    tx_valid, tx_ready, rx_valid, rx_ready;
  logic [N*N-1:0]  tx_dest;
  logic [N*DW-1:0] tx_data, rx_data;
  logic [N*IW-1:0] rx_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [DW-1:0] expq [16][$];

  always #5 clk = ~clk;

  bcast_fabric #(.NCORE(N), .DW(DW), .FDEPTH(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_dest(tx_dest), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_src(rx_src)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic send(input int s, input logic [N-1:0] mask, input logic [DW-1:0] d);
    for (int i = 0; i < 50 && !tx_ready[s]; i++) tick();
    tx_valid[s]             = 1'b1;
    tx_dest[s*N +: N]       = mask;
    tx_data[s*DW +: DW]     = d;
    tick();
    tx_valid[s] = 1'b0;
  endtask

  // scoreboard: pops checked first, then handshakes that complete at the next edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int r = 0; r < N; r++) begin
        if (rx_valid[r] && rx_ready[r]) begin
          int idx;
          idx = r*N + int'(rx_src[r*IW +: IW]);
          if (expq[idx].size() == 0)
            chk(0, "R7 unexpected delivery", idx, -1);
          else begin
            logic [DW-1:0] e;
            e = expq[idx].pop_front();
            chk(rx_data[r*DW +: DW] == e, "R2 R7 payload order", rx_data[r*DW +: DW], e);
          end
        end
      end
      for (int s = 0; s < N; s++)
        if (tx_valid[s] && tx_ready[s])
          for (int r = 0; r < N; r++)
            if (tx_dest[s*N+r]) expq[r*N+s].push_back(tx_data[s*DW +: DW]);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_valid = '0; tx_dest = '0; tx_data = '0; rx_ready = '1;
    #12;
    chk(tx_ready == 4'hF, "R1 ready in reset", tx_ready, 15);
    chk(rx_valid == 4'h0, "R1 valid in reset", rx_valid, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    tick();
    chk(tx_ready == 4'hF, "R1 ready after reset", tx_ready, 15);
    chk(rx_valid == 4'h0, "R1 valid after reset", rx_valid, 0);

    // R2 / R4: every sender to every receiver, one-hot mask
    for (int s = 0; s < N; s++) begin
      for (int r = 0; r < N; r++) begin
        tx_valid[s] = 1'b1; tx_dest = '0; tx_dest[s*N +: N] = 4'(1 << r);
        tx_data[s*DW +: DW] = 8'(8'h40 + s*16 + r);
        tick();
        tx_valid[s] = 1'b0;
        chk(rx_valid == 4'h0, "R4 not yet visible", rx_valid, 0);
        tick();
        chk(rx_valid == 4'(1 << r), "R4 R2 visible at one receiver", rx_valid, 1 << r);
        chk(rx_src[r*IW +: IW] == 2'(s), "R2 source index", rx_src[r*IW +: IW], s);
        chk(rx_data[r*DW +: DW] == 8'(8'h40 + s*16 + r), "R2 data", rx_data[r*DW +: DW], 8'h40 + s*16 + r);
        tick();
        chk(rx_valid == 4'h0, "R2 single copy", rx_valid, 0);
      end
    end

    // R3: broadcast from each sender
    for (int s = 0; s < N; s++) begin
      tx_valid[s] = 1'b1; tx_dest = '0; tx_dest[s*N +: N] = 4'hF;
      tx_data[s*DW +: DW] = 8'(8'hA0 + s);
      tick();
      tx_valid[s] = 1'b0;
      tick();
      chk(rx_valid == 4'hF, "R3 all receivers", rx_valid, 15);
      for (int r = 0; r < N; r++) begin
        chk(rx_src[r*IW +: IW] == 2'(s), "R3 source", rx_src[r*IW +: IW], s);
        chk(rx_data[r*DW +: DW] == 8'(8'hA0 + s), "R3 data", rx_data[r*DW +: DW], 8'hA0 + s);
      end
      tick();
    end

    // R5: all senders at once, distinct receivers
    chk(tx_ready == 4'hF, "R5 all ready", tx_ready, 15);
    for (int s = 0; s < N; s++) begin
      tx_dest[s*N +: N] = 4'(1 << ((s + 1) % N));
      tx_data[s*DW +: DW] = 8'(8'h10 + s);
    end
    tx_valid = 4'hF;
    tick();
    tx_valid = '0;
    tick();
    chk(rx_valid == 4'hF, "R5 all delivered same cycle", rx_valid, 15);
    for (int r = 0; r < N; r++)
      chk(rx_src[r*IW +: IW] == 2'((r + N - 1) % N), "R5 source", rx_src[r*IW +: IW], (r + N - 1) % N);
    tick();

    // R6: four senders hit receiver 0 in one cycle
    for (int s = 0; s < N; s++) begin
      tx_dest[s*N +: N] = 4'h1;
      tx_data[s*DW +: DW] = 8'(8'h20 + s);
    end
    tx_valid = 4'hF;
    tick();
    tx_valid = '0;
    for (int k = 0; k < N; k++) begin
      tick();
      chk(rx_valid[0] == 1'b1, "R6 stream present", rx_valid[0], 1);
      chk(rx_src[1:0] == 2'(k), "R6 ascending sender order", rx_src[1:0], k);
    end
    tick();

    // R8: empty mask
    tx_valid[1] = 1'b1; tx_dest = '0; tx_data[15:8] = 8'h77;
    #1;
    chk(tx_ready[1] == 1'b1, "R8 zero mask taken", tx_ready[1], 1);
    tick();
    tx_valid[1] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(rx_valid == 4'h0, "R8 nothing delivered", rx_valid, 0);
    end

    // R7 / R10 / R9: block receiver 1
    rx_ready = 4'b1101;
    send(0, 4'h2, 8'hC1);
    send(0, 4'h2, 8'hC2);
    send(0, 4'h2, 8'hC3);
    tick(); tick();
    chk(tx_ready[0] == 1'b0, "R7 sender 0 held off", tx_ready[0], 0);
    chk(rx_valid[1] == 1'b1 && rx_data[15:8] == 8'hC1, "R9 head held", rx_data[15:8], 8'hC1);
    send(2, 4'h3, 8'hD1);
    tick(); tick();
    chk(rx_valid[0] == 1'b0, "R10 receiver 0 copy drained", rx_valid[0], 0);
    tx_valid[2] = 1'b1; tx_dest[8 +: 4] = 4'h3; tx_data[16 +: 8] = 8'hD2;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(tx_ready[2] == 1'b0, "R10 multicast held while one target full", tx_ready[2], 0);
      tick();
      chk(rx_valid[0] == 1'b0, "R10 no partial copy", rx_valid[0], 0);
    end
    tx_valid[2] = 1'b0;
    chk(tx_ready[1] == 1'b1, "R5 other sender unaffected", tx_ready[1], 1);
    rx_ready = 4'hF;
    repeat (10) tick();
    chk(tx_ready == 4'hF, "R7 ready returns", tx_ready, 15);
    for (int i = 0; i < 16; i++)
      chk(expq[i].size() == 0, "R7 nothing lost after release", expq[i].size(), 0);

    // R7 / R6: random traffic with random backpressure
    for (int c = 0; c < 4000; c++) begin
      tx_valid = 4'($urandom);
      tx_dest  = 16'($urandom);
      tx_data  = 32'($urandom);
      rx_ready = 4'($urandom) | 4'($urandom);
      tick();
    end
    tx_valid = '0;
    rx_ready = 4'hF;
    repeat (40) tick();
    chk(rx_valid == 4'h0, "R7 drained", rx_valid, 0);
    for (int i = 0; i < 16; i++)
      chk(expq[i].size() == 0, "R7 no loss in random run", expq[i].size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule